// File: doc/BRIEF.md
# Command Macro Processor Core

This block is a small in-order processor that runs short command macros. A macro is a sequence of 32-bit instructions held in a local program RAM, which is filled through a plain write port. A pulse on `start` begins execution at `start_pc`. Operands arrive as a stream of 32-bit arguments on a valid/ready input, and the program turns them into method writes (a 12-bit method address plus a 32-bit data word) on a valid/ready output. The core has eight 32-bit registers, an ALU with a carry flag, bitfield insert and extract operations, a read port into an external register space, and branches with optional delay slots.

Instruction layout: bits [2:0] select the operation, [6:4] the assignment mode, [10:8] the destination, [13:11] source A, [16:14] source B and [21:17] the ALU function. The immediate is the signed 18-bit field [31:14]. Bitfield operations take the source bit position from [21:17], the field width from [26:22] and the destination bit position from [31:27]. For branches, bit 4 picks the condition and bit 5 suppresses the delay slot; bit 7 marks an exit. The method address register keeps the address in bits [11:0] and a 6-bit step in bits [17:12].

Top module: `macro_core`

## Requirements
- R1: A `start` pulse while idle clears all registers and the carry flag, sets the method register to 0, takes the first argument into register 1, and then executes from `start_pc`.
- R2: Register 0 reads as zero whatever is written to it.
- R3: ALU operation (op 0) functions: 0 add, 1 add plus carry, 2 subtract, 3 subtract with an extra 1 taken when carry is 0, 8 XOR, 9 OR, 10 AND, 11 A AND NOT B, 12 NAND. Add sets carry to bit 32 of the sum; subtract sets carry to 1 exactly when no borrow occurs. Only functions 0 to 3 change the carry.
- R4: Op 1 yields source A plus the sign-extended immediate; op 5 drives `xrd_addr` with source A plus the immediate (low 12 bits) and yields `xrd_data`.
- R5: Op 2 copies a field of the given width from B at the source bit into A at the destination bit; op 3 yields (B shifted right by the value of A, masked) shifted left by the destination bit; op 4 yields (B shifted right by the source bit, masked) shifted left by the value of A.
- R6: Assignment modes: 0 writes the next argument to dest; 1 writes the result; 2 writes the result and loads it into the method register; 3 writes the next argument and sends the result; 4 writes and sends the result; 5 writes the next argument and loads the method register from the result; 6 writes the result, loads the method register and sends the next argument; 7 writes the result, loads the method register and sends its step field.
- R7: Every send uses the current method address and then adds the step to it, wrapping at 12 bits; when the same instruction loads the method register, the new value is used.
- R8: Op 7 branches to PC plus the immediate when source A is zero (bit 4 = 0) or nonzero (bit 4 = 1). With bit 5 clear the following instruction runs first as a delay slot; with bit 5 set the jump is immediate. A not-taken branch falls through.
- R9: An instruction with bit 7 set (not a taken branch) ends the program after the following instruction has run; `done` then pulses for one cycle and `busy` falls in the same cycle.
- R10: A branch inside a delay slot pulses `bad_branch` for one cycle and halts without `done` or any send.
- R11: The core waits when an argument is needed and none is valid, or when a send is pending and `mth_ready` is low; a waiting send holds address and data stable, and results do not depend on such waits.
- R12: After reset and while idle, `busy`, `done`, `bad_branch`, `arg_ready` and `mth_valid` are low; a `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pgm_we | input | 1 | Program RAM write enable |
| pgm_addr | input | PW | Program RAM write address |
| pgm_data | input | 32 | Program RAM write data |
| start | input | 1 | Start pulse |
| start_pc | input | PW | First instruction address |
| arg_valid | input | 1 | Argument available |
| arg_ready | output | 1 | Argument taken |
| arg_data | input | 32 | Argument word |
| xrd_addr | output | XAW | External register read address |
| xrd_data | input | 32 | External register read data |
| mth_valid | output | 1 | Method write valid |
| mth_ready | input | 1 | Method write accepted |
| mth_addr | output | 12 | Method address |
| mth_data | output | 32 | Method data |
| busy | output | 1 | Program running or loading first argument |
| done | output | 1 | One-cycle pulse at program end |
| bad_branch | output | 1 | One-cycle pulse on a branch in a delay slot |

## Verification
Almost every internal fault surfaces on the method output: a wrong register, carry or bitfield result changes the data of the next send that depends on it, and a wrong method register shows as a wrong address on the very next send. Control faults such as a lost delay slot or a misplaced exit change the number and order of sends and the cycle of `done`, so each program is checked against the complete list of writes it must produce, with and without throttled handshakes.

// File: rtl/macro_core.sv
`timescale 1ns/1ps
module macro_core #(
  parameter int PW  = 8,
  parameter int XAW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pgm_we,
  input  logic [PW-1:0]  pgm_addr,
  input  logic [31:0]    pgm_data,
  input  logic           start,
  input  logic [PW-1:0]  start_pc,
  input  logic           arg_valid,
  output logic           arg_ready,
  input  logic [31:0]    arg_data,
  output logic [XAW-1:0] xrd_addr,
  input  logic [31:0]    xrd_data,
  output logic           mth_valid,
  input  logic           mth_ready,
  output logic [11:0]    mth_addr,
  output logic [31:0]    mth_data,
  output logic           busy,
  output logic           done,
  output logic           bad_branch
);
  localparam int DEPTH = 2**PW;
  localparam logic [7:0] M_FETCH = 8'b0110_1001;
  localparam logic [7:0] M_WARG  = 8'b0010_1001;
  localparam logic [7:0] M_SEND  = 8'b1101_1000;
  localparam logic [7:0] M_SETM  = 8'b1110_0100;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} st_t;

  logic [31:0]   pgm [DEPTH];
  logic [31:0]   rf [8];
  st_t           st;
  logic [PW-1:0] pc, tgt;
  logic          slot, quit, cy;
  logic [17:0]   mreg;

  always_ff @(posedge clk)
    if (pgm_we) pgm[pgm_addr] <= pgm_data;

  wire [31:0] ins  = pgm[pc];
  wire [2:0]  op   = ins[2:0];
  wire [2:0]  mode = ins[6:4];
  wire [2:0]  dst  = ins[10:8];
  wire [4:0]  aop  = ins[21:17];
  wire [31:0] imm  = {{14{ins[31]}}, ins[31:14]};
  wire [31:0] va   = rf[ins[13:11]];
  wire [31:0] vb   = rf[ins[16:14]];
  wire [31:0] mask = (32'd1 << ins[26:22]) - 32'd1;
  wire [31:0] sum  = va + imm;

  logic [31:0] alu_r, res;
  logic        alu_c;
  logic [32:0] s;

  always_comb begin
    s = '0;
    alu_c = cy;
    alu_r = '0;
    case (aop)
      5'd0: begin s = {1'b0, va} + {1'b0, vb};              alu_c = s[32];  alu_r = s[31:0]; end
      5'd1: begin s = {1'b0, va} + {1'b0, vb} + {32'd0, cy}; alu_c = s[32];  alu_r = s[31:0]; end
      5'd2: begin s = {1'b0, va} - {1'b0, vb};              alu_c = ~s[32]; alu_r = s[31:0]; end
      5'd3: begin s = {1'b0, va} - {1'b0, vb} - {32'd0, ~cy}; alu_c = ~s[32]; alu_r = s[31:0]; end
      5'd8:  alu_r = va ^ vb;
      5'd9:  alu_r = va | vb;
      5'd10: alu_r = va & vb;
      5'd11: alu_r = va & ~vb;
      5'd12: alu_r = ~(va & vb);
      default: alu_r = '0;
    endcase
  end

  always_comb begin
    case (op)
      3'd0: res = alu_r;
      3'd1: res = sum;
      3'd2: res = (va & ~(mask << ins[31:27])) | (((vb >> ins[21:17]) & mask) << ins[31:27]);
      3'd3: res = ((vb >> va) & mask) << ins[31:27];
      3'd4: res = ((vb >> ins[21:17]) & mask) << va;
      3'd5: res = xrd_data;
      default: res = '0;
    endcase
  end

  assign xrd_addr = sum[XAW-1:0];

  wire run     = (st == S_RUN);
  wire is_br   = (op == 3'd7);
  wire take    = ins[4] ? (va != 0) : (va == 0);
  wire illegal = run && is_br && slot;
  wire fch     = run && !is_br && M_FETCH[mode];
  wire snd     = run && !is_br && M_SEND[mode];
  wire step    = run && (!fch || arg_valid) && (!snd || mth_ready);
  wire [17:0] mnew = M_SETM[mode] ? res[17:0] : mreg;
  wire [31:0] wval = M_WARG[mode] ? arg_data : res;

  assign busy      = (st != S_IDLE);
  assign mth_valid = snd && (!fch || arg_valid);
  assign arg_ready = (st == S_LOAD) || (fch && (!snd || mth_ready));
  assign mth_addr  = mnew[11:0];
  assign mth_data  = (mode == 3'd6) ? arg_data :
                     (mode == 3'd7) ? {26'd0, mnew[17:12]} : res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; tgt <= '0; slot <= 1'b0; quit <= 1'b0;
      cy <= 1'b0; mreg <= '0; done <= 1'b0; bad_branch <= 1'b0;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else begin
      done <= 1'b0;
      bad_branch <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_LOAD; pc <= start_pc; slot <= 1'b0; quit <= 1'b0;
          cy <= 1'b0; mreg <= '0;
          for (int i = 0; i < 8; i++) rf[i] <= '0;
        end
        S_LOAD: if (arg_valid) begin
          rf[1] <= arg_data;
          st <= S_RUN;
        end
        default: if (illegal) begin
          st <= S_IDLE;
          bad_branch <= 1'b1;
        end else if (step) begin
          if (!is_br) begin
            if (dst != 3'd0) rf[dst] <= wval;
            if (op == 3'd0 && aop[4:2] == 3'd0) cy <= alu_c;
            if (snd) mreg <= {mnew[17:12], mnew[11:0] + {6'd0, mnew[17:12]}};
            else if (M_SETM[mode]) mreg <= mnew;
          end
          if (slot) begin
            slot <= 1'b0;
            if (quit) begin st <= S_IDLE; done <= 1'b1; end
            else pc <= tgt;
          end else if (is_br && take) begin
            if (ins[5]) pc <= pc + imm[PW-1:0];
            else begin pc <= pc + 1'b1; tgt <= pc + imm[PW-1:0]; slot <= 1'b1; end
          end else if (ins[7]) begin
            pc <= pc + 1'b1; slot <= 1'b1; quit <= 1'b1;
          end else begin
            pc <= pc + 1'b1;
          end
        end
      endcase
    end
  end

  p_mth_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mth_valid && !mth_ready && !fch |=> mth_valid && $stable(mth_addr) && $stable(mth_data));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !bad_branch);
  p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_bad_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_branch |-> !busy && !done);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !arg_ready && !mth_valid);
endmodule

// File: tb/sim_macro_core.sv
`timescale 1ns/1ps
module sim_macro_core;
  localparam int PW = 8;
  localparam int XAW = 12;
  localparam logic [31:0] XT = 32'h80;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, pgm_we = 1'b0, start = 1'b0, mth_ready = 1'b1;
  logic [PW-1:0] pgm_addr = '0, start_pc = '0;
  logic [31:0] pgm_data = '0;
  logic arg_valid, arg_ready, mth_valid, busy, done, bad_branch;
  logic [31:0] arg_data, xrd_data, mth_data;
  logic [XAW-1:0] xrd_addr;
  logic [11:0] mth_addr;

  logic [31:0] abuf [64];
  int ah = 0, at = 0, cyc = 0, nc = 0;
  bit ahold = 0, apat = 0, rpat = 0, pp = 0;
  logic [11:0] ca [64];
  logic [31:0] cd [64];
  int compared = 0, mismatched = 0;

  assign arg_valid = (ah < at) && !ahold && (!apat || (cyc % 2 == 0));
  assign arg_data  = abuf[ah % 64];
  assign xrd_data  = 32'h5A000000 | 32'(xrd_addr);

  macro_core #(.PW(PW), .XAW(XAW)) u0 (
    .clk(clk), .rst_n(rst_n), .pgm_we(pgm_we), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .start(start), .start_pc(start_pc), .arg_valid(arg_valid), .arg_ready(arg_ready),
    .arg_data(arg_data), .xrd_addr(xrd_addr), .xrd_data(xrd_data), .mth_valid(mth_valid),
    .mth_ready(mth_ready), .mth_addr(mth_addr), .mth_data(mth_data), .busy(busy),
    .done(done), .bad_branch(bad_branch));

  always @(negedge clk) begin
    pp = arg_valid && arg_ready;
    if (mth_valid && mth_ready && nc < 64) begin
      ca[nc] = mth_addr; cd[nc] = mth_data; nc++;
    end
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    if (pp) ah++;
    pp = 0;
    mth_ready = !rpat || (cyc % 3 != 0);
  end

  function automatic logic [31:0] e_alu(int aop, int md, int d, int a, int b);
    return {10'd0, 5'(aop), 3'(b), 3'(a), 3'(d), 1'b0, 3'(md), 1'b0, 3'd0};
  endfunction
  function automatic logic [31:0] e_imm(int op, int md, int d, int a, int imm);
    return {18'(imm), 3'(a), 3'(d), 1'b0, 3'(md), 1'b0, 3'(op)};
  endfunction
  function automatic logic [31:0] e_bf(int op, int md, int d, int a, int b, int sb, int sz, int db);
    return {5'(db), 5'(sz), 5'(sb), 3'(b), 3'(a), 3'(d), 1'b0, 3'(md), 1'b0, 3'(op)};
  endfunction
  function automatic logic [31:0] e_br(int cond, int nd, int a, int imm);
    return {18'(imm), 3'(a), 3'd0, 1'b0, 1'b0, 1'(nd), 1'(cond), 1'b0, 3'd7};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pw(input int a, input logic [31:0] w);
    @(posedge clk); #1;
    pgm_we = 1'b1; pgm_addr = PW'(a); pgm_data = w;
  endtask
  task automatic pwend();
    @(posedge clk); #1;
    pgm_we = 1'b0;
  endtask

  task automatic kick(input int pc);
    nc = 0;
    @(posedge clk); #1;
    start = 1'b1; start_pc = PW'(pc);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic finish_run(output int nd, output int nb);
    nd = 0; nb = 0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (done) nd++;
      if (bad_branch) nb++;
      if (!busy) begin
        @(negedge clk);
        if (done) nd++;
        if (bad_branch) nb++;
        return;
      end
    end
    chk("watchdog run", 32'd1, 32'd0);
  endtask

  task automatic cap(input string tag, input int i, input logic [11:0] a, input logic [31:0] d);
    chk({tag, " addr"}, 32'(ca[i]), 32'(a));
    chk({tag, " data"}, cd[i], d);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 reset busy", 32'(busy), 0);
    chk("R12 reset done", 32'(done), 0);
    chk("R12 reset bad", 32'(bad_branch), 0);
    chk("R12 reset arg_ready", 32'(arg_ready), 0);
    chk("R12 reset mth_valid", 32'(mth_valid), 0);
  endtask

  task automatic load_basic();
    pw(0, e_imm(1, 2, 0, 0, (1 << 12) | 'h10));
    pw(1, e_alu(0, 4, 2, 1, 0));
    pw(2, e_alu(9, 4, 3, 0, 0) | XT);
    pw(3, e_alu(0, 4, 0, 2, 2));
    pw(4, e_imm(1, 4, 0, 0, 'hDEAD));
    pwend();
  endtask

  task automatic t_basic();
    int nd, nb;
    abuf[0] = 32'h1234; ah = 0; at = 1;
    kick(0);
    finish_run(nd, nb);
    chk("R9 done pulses once", 32'(nd), 1);
    chk("R10 no bad", 32'(nb), 0);
    chk("R9 sends incl. slot, none after", 32'(nc), 3);
    cap("R1 first arg in r1", 0, 12'h010, 32'h1234);
    cap("R2 r0 reads zero", 1, 12'h011, 32'h0);
    cap("R9 exit slot runs", 2, 12'h012, 32'h2468);
  endtask

  task automatic t_alu();
    int nd, nb;
    int b = 16;
    pw(b+0,  e_imm(1, 2, 0, 0, (1 << 12) | 'h20));
    pw(b+1,  e_alu(0, 0, 2, 0, 0));
    pw(b+2,  e_alu(0, 4, 3, 1, 2));
    pw(b+3,  e_alu(1, 4, 4, 0, 0));
    pw(b+4,  e_alu(2, 4, 5, 0, 2));
    pw(b+5,  e_alu(3, 4, 5, 2, 0));
    pw(b+6,  e_alu(3, 4, 5, 2, 0));
    pw(b+7,  e_alu(8, 4, 6, 1, 2));
    pw(b+8,  e_alu(9, 4, 6, 2, 0));
    pw(b+9,  e_alu(10, 4, 6, 1, 2));
    pw(b+10, e_alu(11, 4, 6, 1, 2));
    pw(b+11, e_alu(12, 4, 6, 1, 1) | XT);
    pw(b+12, e_alu(0, 1, 0, 1, 1));
    pwend();
    abuf[0] = 32'hFFFFFFFF; abuf[1] = 32'h1; ah = 0; at = 2;
    kick(b);
    finish_run(nd, nb);
    chk("R1 start offset done", 32'(nd), 1);
    chk("R3 send count", 32'(nc), 10);
    cap("R3 add wraps", 0, 12'h020, 32'h0);
    cap("R3 add carry in", 1, 12'h021, 32'h1);
    cap("R3 sub borrow", 2, 12'h022, 32'hFFFFFFFF);
    cap("R3 subb carry0", 3, 12'h023, 32'h0);
    cap("R3 subb carry1", 4, 12'h024, 32'h1);
    cap("R3 xor", 5, 12'h025, 32'hFFFFFFFE);
    cap("R3 or", 6, 12'h026, 32'h1);
    cap("R3 and", 7, 12'h027, 32'h1);
    cap("R3 andnot", 8, 12'h028, 32'hFFFFFFFE);
    cap("R3 nand", 9, 12'h029, 32'h0);
  endtask

  task automatic t_bitfield();
    int nd, nb;
    int b = 40;
    pw(b+0, e_imm(1, 2, 0, 0, (1 << 12) | 'h30));
    pw(b+1, e_bf(2, 4, 2, 0, 1, 4, 8, 16));
    pw(b+2, e_imm(1, 1, 5, 0, 8));
    pw(b+3, e_bf(3, 4, 3, 5, 1, 0, 8, 0));
    pw(b+4, e_bf(4, 4, 4, 5, 1, 28, 4, 0));
    pw(b+5, e_imm(1, 4, 6, 5, -3));
    pw(b+6, e_imm(5, 4, 7, 5, 'h100) | XT);
    pw(b+7, e_imm(1, 4, 0, 0, -1));
    pwend();
    abuf[0] = 32'hABCD1234; ah = 0; at = 1;
    kick(b);
    finish_run(nd, nb);
    chk("R5 send count", 32'(nc), 6);
    cap("R5 replace", 0, 12'h030, 32'h00230000);
    cap("R5 extract by reg shift", 1, 12'h031, 32'h12);
    cap("R5 extract shl by reg", 2, 12'h032, 32'hA00);
    cap("R4 add negative imm", 3, 12'h033, 32'h5);
    cap("R4 external read", 4, 12'h034, 32'h5A000108);
    cap("R4 sign extend", 5, 12'h035, 32'hFFFFFFFF);
  endtask

  task automatic load_modes();
    int b = 60;
    pw(b+0, e_imm(1, 5, 2, 0, (2 << 12) | 'h40));
    pw(b+1, e_alu(0, 3, 3, 1, 2));
    pw(b+2, e_imm(1, 6, 4, 0, (3 << 12) | 'h50));
    pw(b+3, e_imm(1, 7, 0, 0, (5 << 12) | 'h60));
    pw(b+4, e_alu(0, 4, 0, 3, 4) | XT);
    pw(b+5, e_alu(9, 4, 0, 4, 0));
    pwend();
  endtask

  task automatic t_modes(input string tag);
    int nd, nb;
    abuf[0] = 32'h11; abuf[1] = 32'h22; abuf[2] = 32'h33; abuf[3] = 32'h44;
    ah = 0; at = 4;
    kick(60);
    finish_run(nd, nb);
    chk({tag, " done"}, 32'(nd), 1);
    chk({tag, " args used"}, 32'(ah), 4);
    chk({tag, " send count"}, 32'(nc), 5);
    cap({tag, " R6 fetch+send result"}, 0, 12'h040, 32'h33);
    cap({tag, " R6 set method send arg"}, 1, 12'h050, 32'h44);
    cap({tag, " R6 send step"}, 2, 12'h060, 32'h5);
    cap({tag, " R7 step applied"}, 3, 12'h065, 32'h3083);
    cap({tag, " R7 step again"}, 4, 12'h06A, 32'h3050);
  endtask

  task automatic t_branch();
    int nd, nb;
    int b = 80;
    pw(b+0, e_imm(1, 2, 0, 0, (1 << 12) | 'h70));
    pw(b+1, e_alu(0, 4, 0, 1, 0));
    pw(b+2, e_imm(1, 1, 1, 1, -1));
    pw(b+3, e_br(1, 0, 1, -2));
    pw(b+4, e_imm(1, 4, 0, 0, 'h77));
    pw(b+5, e_br(0, 1, 0, 2));
    pw(b+6, e_imm(1, 4, 0, 0, 'hBAD));
    pw(b+7, e_imm(1, 2, 0, 0, (1 << 12) | 'hFFF));
    pw(b+8, e_imm(1, 4, 0, 0, 'h55) | XT);
    pw(b+9, e_imm(1, 4, 0, 0, 'h66));
    pwend();
    abuf[0] = 32'h3; ah = 0; at = 1;
    kick(b);
    finish_run(nd, nb);
    chk("R8 send count", 32'(nc), 8);
    cap("R8 loop 1", 0, 12'h070, 32'h3);
    cap("R8 delay slot 1", 1, 12'h071, 32'h77);
    cap("R8 loop 2", 2, 12'h072, 32'h2);
    cap("R8 delay slot 2", 3, 12'h073, 32'h77);
    cap("R8 loop 3", 4, 12'h074, 32'h1);
    cap("R8 not taken falls through", 5, 12'h075, 32'h77);
    cap("R8 no-delay skips", 6, 12'hFFF, 32'h55);
    cap("R7 address wraps", 7, 12'h000, 32'h66);
  endtask

  task automatic t_illegal();
    int nd, nb;
    int b = 100;
    pw(b+0, e_br(0, 0, 0, 5));
    pw(b+1, e_br(0, 1, 0, 1));
    pw(b+2, e_imm(1, 4, 0, 0, 'h99));
    pwend();
    abuf[0] = 32'h0; ah = 0; at = 1;
    kick(b);
    finish_run(nd, nb);
    chk("R10 bad pulse once", 32'(nb), 1);
    chk("R10 no done", 32'(nd), 0);
    chk("R10 no send", 32'(nc), 0);
  endtask

  task automatic t_start_busy();
    int nd, nb;
    abuf[0] = 32'h1234; ah = 0; at = 1;
    ahold = 1;
    kick(0);
    repeat (4) @(negedge clk);
    chk("R11 waits for first arg", 32'(busy), 1);
    @(posedge clk); #1;
    start = 1'b1; start_pc = 8'd80;
    @(posedge clk); #1;
    start = 1'b0;
    ahold = 0;
    finish_run(nd, nb);
    chk("R12 restart ignored done", 32'(nd), 1);
    chk("R12 restart ignored count", 32'(nc), 3);
    cap("R12 original program ran", 0, 12'h010, 32'h1234);
    cap("R12 original program ran", 2, 12'h012, 32'h2468);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog global", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    load_basic();
    t_basic();
    t_alu();
    t_bitfield();
    load_modes();
    t_modes("R6 plain");
    t_branch();
    t_illegal();
    rpat = 1; apat = 1;
    t_modes("R11 throttled");
    rpat = 0; apat = 0;
    t_start_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule